// File: doc/BRIEF.md
# SDRAM Low-Power Sequencer

This block sits between a memory controller's command scheduler and the SDRAM pins. It decides when the memory may enter its clock-enable power-saving state and when it must leave it. In normal operation it passes the scheduler's command word to the command pins, delayed by one register. When a sleep request is accepted, the block drops the clock enable. On that same edge it presents a no-operation or deselect word, so the device registers the low clock enable together with a harmless command.

Each entry is classified from the per-bank open-row flags. With no bank open the state is reported as precharge power-down. With at least one row open it is reported as active power-down. A sleep request that arrives while the scheduler still has an access in flight is held and never dropped. The device keeps no refresh going while powered down, so the block bounds the dwell. It forces a wake-up a configurable margin before the refresh limit and then pulses a refresh-due flag toward the refresh logic.

On exit, the clock enable rises while the command pins carry a no-operation. The no-operation is held for a setup window, followed by a settle window. Only after both windows does the block report ready, so the scheduler can issue commands again.

Top module: `sdram_lowpower_seq`

## Requirements
- R1: After reset the outputs are cke=1, cmd=4'b0111 (no-operation, bit order {cs_n,ras_n,cas_n,we_n}), ready=1, pd_active=0, pd_kind=0, refresh_due=0.
- R2: While ready is high and no entry takes place, cmd equals the host_cmd value sampled on the previous clock edge and cke stays 1.
- R3: A sleep request accepted with access_busy low brings cke to 0 on the next edge. On that edge cmd becomes the park word (4'b0111 by default, 4'b1111 deselect when PARK_DESELECT=1) whatever host_cmd is, pd_active becomes 1 and ready becomes 0.
- R4: A sleep_req pulse seen while access_busy is high is remembered. Entry takes place on the first edge at which access_busy is low.
- R5: pd_kind is captured on the entry edge: 0 (precharge power-down) when every bank_open bit is 0, 1 (active power-down) otherwise. It keeps that value until the next entry.
- R6: While powered down, cke stays 0 and cmd stays at the park word regardless of host_cmd.
- R7: wake_req while powered down raises cke on the next edge with cmd=4'b0111 and pd_active=0. cmd stays 4'b0111 and ready stays 0 for CKS_CYCLES+HOLD_CYCLES cycles, then ready returns to 1.
- R8: Without wake_req, cke stays low for exactly REFRESH_LIMIT-WAKE_MARGIN cycles and then rises, following the same exit sequence as R7.
- R9: refresh_due is a one-cycle pulse on the cycle ready returns after a forced exit. It stays 0 after a requested exit.
- R10: wake_req while not powered down has no effect on any output.
- R11: A sleep_req seen during the exit windows is held. Ready is then high for one cycle and entry follows on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_cmd | input | 4 | Scheduler command word {cs_n,ras_n,cas_n,we_n} |
| access_busy | input | 1 | A read or write is still in progress |
| bank_open | input | NUM_BANKS | One bit per bank, 1 when a row is open |
| sleep_req | input | 1 | Request to enter power-down (pulse or level) |
| wake_req | input | 1 | Request to leave power-down |
| cke | output | 1 | Clock enable to the memory |
| cmd | output | 4 | Command pins {cs_n,ras_n,cas_n,we_n} |
| pd_active | output | 1 | Memory is in power-down |
| pd_kind | output | 1 | 0 precharge power-down, 1 active power-down |
| ready | output | 1 | Scheduler may issue commands |
| refresh_due | output | 1 | One-cycle pulse after a forced wake-up |

## Verification
The hardest situation to reach from the ports is a sleep request that arrives during the exit windows of a forced wake-up. Reaching it means letting the dwell limit expire with no wake request. The bench then injects the request at a known cycle inside the setup window. The bench uses a short refresh limit, so the whole dwell completes in a few dozen cycles. This makes the single-cycle ready, the refresh-due pulse and the immediate re-entry (now classified from cleared bank flags) land at cycles computed in advance.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

    typedef enum logic [1:0] {
        LP_RUN    = 2'd0,
        LP_DOWN   = 2'd1,
        LP_WAKE   = 2'd2,
        LP_SETTLE = 2'd3
    } lp_mode_e;

    // Command word bit order: {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP      = 4'b0111;
    localparam logic [3:0] CMD_DESELECT = 4'b1111;

endpackage

// File: rtl/sdram_lp_bank_scan.sv
module sdram_lp_bank_scan #(
    parameter int NUM_BANKS = 4
) (
    input  logic [NUM_BANKS-1:0] bank_open,
    output logic                 any_open
);

    logic [NUM_BANKS:0] chain;

    assign chain[0] = 1'b0;

    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_scan
            assign chain[g+1] = chain[g] | bank_open[g];
        end
    endgenerate

    assign any_open = chain[NUM_BANKS];

endmodule

// File: rtl/sdram_lp_dwell.sv
module sdram_lp_dwell #(
    parameter int DWELL_CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);

    localparam int DW_W = $clog2(DWELL_CYCLES + 1);
    localparam logic [DW_W-1:0] LAST = DW_W'(DWELL_CYCLES - 1);

    logic [DW_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q + DW_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expire = run && (cnt_q == LAST);

endmodule

// File: rtl/sdram_lp_cmd_sel.sv
module sdram_lp_cmd_sel
    import sdram_lp_pkg::*;
#(
    parameter int PARK_DESELECT = 0
) (
    input  lp_mode_e   mode_next,
    input  logic [3:0] host_cmd,
    output logic [3:0] cmd_next
);

    logic [3:0] park_word;

    generate
        if (PARK_DESELECT != 0) begin : g_park_deselect
            assign park_word = CMD_DESELECT;
        end else begin : g_park_nop
            assign park_word = CMD_NOP;
        end
    endgenerate

    always_comb begin
        unique case (mode_next)
            LP_RUN:  cmd_next = host_cmd;
            LP_DOWN: cmd_next = park_word;
            default: cmd_next = CMD_NOP;
        endcase
    end

endmodule

// File: rtl/sdram_lowpower_seq.sv
module sdram_lowpower_seq
    import sdram_lp_pkg::*;
#(
    parameter int NUM_BANKS     = 4,
    parameter int REFRESH_LIMIT = 12800,
    parameter int WAKE_MARGIN   = 64,
    parameter int CKS_CYCLES    = 1,
    parameter int HOLD_CYCLES   = 2,
    parameter int PARK_DESELECT = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [3:0]           host_cmd,
    input  logic                 access_busy,
    input  logic [NUM_BANKS-1:0] bank_open,
    input  logic                 sleep_req,
    input  logic                 wake_req,
    output logic                 cke,
    output logic [3:0]           cmd,
    output logic                 pd_active,
    output logic                 pd_kind,
    output logic                 ready,
    output logic                 refresh_due
);

    localparam int DWELL_CYCLES = REFRESH_LIMIT - WAKE_MARGIN;
    localparam int PH_MAX       = (CKS_CYCLES > HOLD_CYCLES) ? CKS_CYCLES : HOLD_CYCLES;
    localparam int PH_W         = $clog2(PH_MAX + 1);
    localparam logic [PH_W-1:0] CKS_LAST  = PH_W'(CKS_CYCLES - 1);
    localparam logic [PH_W-1:0] HOLD_LAST = PH_W'(HOLD_CYCLES - 1);

    typedef struct packed {
        lp_mode_e        mode;
        logic [PH_W-1:0] phase;
        logic            pend;
        logic            kind;
        logic            forced;
        logic            cke;
        logic            ready;
        logic            pd_active;
        logic            refresh_due;
    } lp_state_t;

    lp_state_t  s_d, s_q;
    logic [3:0] cmd_d, cmd_q;
    logic       any_open;
    logic       expire;
    logic       pend_now;

    sdram_lp_bank_scan #(
        .NUM_BANKS (NUM_BANKS)
    ) u_scan (
        .bank_open (bank_open),
        .any_open  (any_open)
    );

    sdram_lp_dwell #(
        .DWELL_CYCLES (DWELL_CYCLES)
    ) u_dwell (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (s_q.mode == LP_DOWN),
        .expire (expire)
    );

    sdram_lp_cmd_sel #(
        .PARK_DESELECT (PARK_DESELECT)
    ) u_cmd (
        .mode_next (s_d.mode),
        .host_cmd  (host_cmd),
        .cmd_next  (cmd_d)
    );

    // Next-state computation
    always_comb begin
        s_d             = s_q;
        s_d.refresh_due = 1'b0;
        pend_now        = s_q.pend | sleep_req;

        unique case (s_q.mode)
            LP_RUN: begin
                if (pend_now && !access_busy) begin
                    s_d.mode   = LP_DOWN;
                    s_d.pend   = 1'b0;
                    s_d.kind   = any_open;
                    s_d.forced = 1'b0;
                end else begin
                    s_d.pend = pend_now;
                end
            end
            LP_DOWN: begin
                s_d.pend = 1'b0;
                if (expire || wake_req) begin
                    s_d.mode   = LP_WAKE;
                    s_d.phase  = '0;
                    s_d.forced = expire;
                end
            end
            LP_WAKE: begin
                s_d.pend = pend_now;
                if (s_q.phase == CKS_LAST) begin
                    s_d.mode  = LP_SETTLE;
                    s_d.phase = '0;
                end else begin
                    s_d.phase = s_q.phase + PH_W'(1);
                end
            end
            LP_SETTLE: begin
                s_d.pend = pend_now;
                if (s_q.phase == HOLD_LAST) begin
                    s_d.mode        = LP_RUN;
                    s_d.phase       = '0;
                    s_d.refresh_due = s_q.forced;
                    s_d.forced      = 1'b0;
                end else begin
                    s_d.phase = s_q.phase + PH_W'(1);
                end
            end
            default: begin
                s_d.mode = LP_RUN;
            end
        endcase

        s_d.cke       = (s_d.mode != LP_DOWN);
        s_d.pd_active = (s_d.mode == LP_DOWN);
        s_d.ready     = (s_d.mode == LP_RUN);
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mode        <= LP_RUN;
            s_q.phase       <= '0;
            s_q.pend        <= 1'b0;
            s_q.kind        <= 1'b0;
            s_q.forced      <= 1'b0;
            s_q.cke         <= 1'b1;
            s_q.ready       <= 1'b1;
            s_q.pd_active   <= 1'b0;
            s_q.refresh_due <= 1'b0;
            cmd_q           <= CMD_NOP;
        end else begin
            s_q   <= s_d;
            cmd_q <= cmd_d;
        end
    end

    assign cke         = s_q.cke;
    assign cmd         = cmd_q;
    assign pd_active   = s_q.pd_active;
    assign pd_kind     = s_q.kind;
    assign ready       = s_q.ready;
    assign refresh_due = s_q.refresh_due;

endmodule

// File: rtl/sdram_lowpower_seq_chk.sv
module sdram_lowpower_seq_chk #(
    parameter int REFRESH_LIMIT = 12800,
    parameter int WAKE_MARGIN   = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       access_busy,
    input logic       cke,
    input logic [3:0] cmd,
    input logic       ready,
    input logic       pd_kind,
    input logic       refresh_due
);

    localparam int DWELL = REFRESH_LIMIT - WAKE_MARGIN;
    localparam int LW    = $clog2(REFRESH_LIMIT + 2);

    logic [LW-1:0] low_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!cke) begin
            low_run <= low_run + LW'(1);
        end else begin
            low_run <= '0;
        end
    end

    AST_ENTRY_HARMLESS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> (cmd == 4'b0111 || cmd[3])); // R3

    AST_ENTRY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> !ready); // R3

    AST_ENTRY_IDLE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cke) |-> !$past(access_busy)); // R4

    AST_KIND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(cke) |-> $stable(pd_kind)); // R5

    AST_PARKED_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cke && $past(!cke)) |-> $stable(cmd)); // R6

    AST_EXIT_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cke) |-> (!ready && cmd == 4'b0111)); // R7

    AST_DWELL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> (low_run < LW'(DWELL))); // R8

    AST_REFRESH_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_due |-> $rose(ready)); // R9

endmodule

bind sdram_lowpower_seq sdram_lowpower_seq_chk #(
    .REFRESH_LIMIT (REFRESH_LIMIT),
    .WAKE_MARGIN   (WAKE_MARGIN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .access_busy (access_busy),
    .cke         (cke),
    .cmd         (cmd),
    .ready       (ready),
    .pd_kind     (pd_kind),
    .refresh_due (refresh_due)
);

// File: tb/sdram_lowpower_seq_test.sv
`timescale 1ns/1ps
module sdram_lowpower_seq_test;

    localparam int NB      = 4;
    localparam int RLIM    = 60;
    localparam int MARGIN  = 10;
    localparam int DWELL   = RLIM - MARGIN;
    localparam int CKS     = 2;
    localparam int HOLD    = 3;
    localparam logic [3:0] NOP = 4'b0111;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [3:0]    host_cmd = NOP;
    logic          access_busy = 1'b0;
    logic [NB-1:0] bank_open = '0;
    logic          sleep_req = 1'b0;
    logic          wake_req = 1'b0;
    logic          cke, pd_active, pd_kind, ready, refresh_due;
    logic [3:0]    cmd;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        int         at;
        logic       cke;
        logic [3:0] cmd;
        logic       rdy;
        logic       pd;
        logic       kind;
        logic       rd;
        string      tag;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) cyc <= cyc + 1;

    sdram_lowpower_seq #(
        .NUM_BANKS     (NB),
        .REFRESH_LIMIT (RLIM),
        .WAKE_MARGIN   (MARGIN),
        .CKS_CYCLES    (CKS),
        .HOLD_CYCLES   (HOLD),
        .PARK_DESELECT (0)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_cmd    (host_cmd),
        .access_busy (access_busy),
        .bank_open   (bank_open),
        .sleep_req   (sleep_req),
        .wake_req    (wake_req),
        .cke         (cke),
        .cmd         (cmd),
        .pd_active   (pd_active),
        .pd_kind     (pd_kind),
        .ready       (ready),
        .refresh_due (refresh_due)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_at(input int off, input logic e_cke, input logic [3:0] e_cmd,
                             input logic e_rdy, input logic e_pd, input logic e_kind,
                             input logic e_rd, input string tag);
        exp_t e;
        e.at = cyc + off; e.cke = e_cke; e.cmd = e_cmd; e.rdy = e_rdy;
        e.pd = e_pd; e.kind = e_kind; e.rd = e_rd; e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compares outputs at the falling edge of the scheduled cycle
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0 && sb[0].at <= cyc) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (e.at < cyc) begin
                    fails++;
                    $display("FAIL %s: sample for cycle %0d missed (now %0d)", e.tag, e.at, cyc);
                end else if (cke !== e.cke || cmd !== e.cmd || ready !== e.rdy ||
                             pd_active !== e.pd || pd_kind !== e.kind || refresh_due !== e.rd) begin
                    fails++;
                    $display("FAIL %s cycle %0d: got cke=%b cmd=%b rdy=%b pd=%b kind=%b rd=%b, expected cke=%b cmd=%b rdy=%b pd=%b kind=%b rd=%b",
                             e.tag, cyc, cke, cmd, ready, pd_active, pd_kind, refresh_due,
                             e.cke, e.cmd, e.rdy, e.pd, e.kind, e.rd);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    // Driver
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        expect_at(0, 1'b1, NOP, 1'b1, 1'b0, 1'b0, 1'b0, "R1");

        // R2: pass-through of host commands
        host_cmd = 4'b0011;
        expect_at(1, 1'b1, 4'b0011, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
        step();
        host_cmd = 4'b0101;
        expect_at(1, 1'b1, 4'b0101, 1'b1, 1'b0, 1'b0, 1'b0, "R2");
        step();

        // R10: wake request while running changes nothing
        host_cmd = NOP;
        wake_req = 1'b1;
        expect_at(1, 1'b1, NOP, 1'b1, 1'b0, 1'b0, 1'b0, "R10");
        step();
        wake_req = 1'b0;

        // R3 / R5: entry with all banks idle, host word overridden
        host_cmd  = 4'b0000;
        bank_open = '0;
        sleep_req = 1'b1;
        expect_at(1, 1'b0, NOP, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
        step();
        sleep_req = 1'b0;

        // R6: host word ignored while powered down
        for (int i = 0; i < 4; i++) begin
            host_cmd = 4'(i);
            expect_at(1, 1'b0, NOP, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
            step();
        end

        // R7 / R9: requested exit, no refresh pulse
        host_cmd = NOP;
        wake_req = 1'b1;
        for (int k = 1; k <= CKS + HOLD; k++) begin
            expect_at(k, 1'b1, NOP, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        end
        expect_at(CKS + HOLD + 1, 1'b1, NOP, 1'b1, 1'b0, 1'b0, 1'b0, "R9");
        step();
        wake_req = 1'b0;
        repeat (CKS + HOLD) step();

        // R4: request held while an access is in progress
        access_busy = 1'b1;
        sleep_req   = 1'b1;
        bank_open   = 4'b0100;
        expect_at(1, 1'b1, NOP, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        step();
        sleep_req = 1'b0;
        expect_at(1, 1'b1, NOP, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        step();
        expect_at(1, 1'b1, NOP, 1'b1, 1'b0, 1'b0, 1'b0, "R4");
        step();
        access_busy = 1'b0;
        expect_at(1, 1'b0, NOP, 1'b0, 1'b1, 1'b1, 1'b0, "R4_R5");
        step();

        // R8: forced exit after the dwell limit (first powered-down cycle is now)
        expect_at(DWELL - 1, 1'b0, NOP, 1'b0, 1'b1, 1'b1, 1'b0, "R8");
        expect_at(DWELL,     1'b1, NOP, 1'b0, 1'b0, 1'b1, 1'b0, "R8");
        repeat (DWELL + 1) step();

        // R11: sleep request during the setup window of a forced exit
        sleep_req = 1'b1;
        bank_open = '0;
        expect_at(CKS + HOLD - 1, 1'b1, NOP, 1'b1, 1'b0, 1'b1, 1'b1, "R9");
        expect_at(CKS + HOLD,     1'b0, NOP, 1'b0, 1'b1, 1'b0, 1'b0, "R11");
        step();
        sleep_req = 1'b0;
        repeat (CKS + HOLD - 1) step();

        // R7: leave the second power-down on request
        wake_req = 1'b1;
        expect_at(1, 1'b1, NOP, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
        step();
        wake_req = 1'b0;
        repeat (8) step();

        done = 1'b1;
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: %0d items left, expected 0", sb.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule